// File: doc/BRIEF.md
# AAL1 Cell Payload Builder

This block turns a byte stream of user data into 48-octet cell payloads for circuit-emulation traffic. Each payload starts with a one-octet header. The header carries a 4-bit sequence number and a 4-bit protection field. The sequence number is a CS-indication bit followed by a 3-bit count that wraps modulo 8. The protection field is a 3-bit CRC followed by an even-parity bit. Any remaining space is filled with user octets taken from the input stream.

In structured mode the upstream logic can ask for a pointer octet on a cell. It does this by holding `ptr_req` and a 7-bit `ptr_offset` while the cell's first user octet is offered. The request is honoured only when the count is even. On such a cell the CS bit is set and a pointer octet (parity, then offset) follows the header, which leaves 46 user octets instead of 47. An offset of 127 is the agreed "no boundary in this pair of cells" value and passes through unchanged.

The input uses a valid/ready handshake. The output is a valid byte stream with a start-of-cell flag on the header octet. Outer cell headers, scheduling and line interfaces belong to neighbouring blocks.

Top module: `aal1_cell_builder`

## Requirements
- R1: A synchronous reset drops `out_valid` and `in_ready` on the following cycle and makes the next header's sequence count 0.
- R2: Header bit 7 is the CS indication and bits 6:4 are the sequence count; the count rises by one per cell and wraps from 7 to 0.
- R3: Header bits 3:1 are the remainder of (bits 7:4 times x^3) divided by x^3+x+1, and bit 0 makes the number of ones in the header octet even.
- R4: When `ptr_req` is high at the cycle the header is produced and the count is even, header bit 7 is 1 and the next octet is the pointer: bit 7 makes that octet's ones count even and bits 6:0 equal `ptr_offset` (127 included).
- R5: A pointer request on an odd count is ignored: bit 7 of the header is 0, no pointer octet is inserted and 47 user octets follow.
- R6: Every cell is exactly 48 octets; a cell with a pointer holds 46 user octets, one without holds 47.
- R7: `in_ready` is low while a header is awaited or output and while a pointer octet is output. User octets leave in arrival order, unchanged, whatever the gaps on `in_valid`.
- R8: `out_sop` is high on the header octet only, once per cell.
- R9: The header appears one cycle after the first clock edge in the idle state with `in_valid` high; each accepted user octet appears one cycle after its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | User octet offered |
| in_data | input | 8 | User octet |
| in_ready | output | 1 | Builder accepts a user octet this cycle |
| ptr_req | input | 1 | Request a pointer octet in the cell about to start |
| ptr_offset | input | 7 | Offset carried by the pointer octet |
| out_valid | output | 1 | Output octet present |
| out_sop | output | 1 | Output octet is a cell header |
| out_data | output | 8 | Output octet |

## Verification
All outputs are registered. A header shows one cycle after the edge at which the idle builder sees `in_valid`. A pointer octet follows one cycle later. A user octet shows one cycle after the edge that accepted it. With no gaps, `in_ready` first rises one cycle after the header edge, or two cycles after it when a pointer is inserted. The bench drives and samples on falling edges. It decides a handshake from `in_ready` as seen at the falling edge before the accepting rising edge, and reads the matching output at the next falling edge. Whole cells are collected by a monitor and compared after the last octet has had a full cycle to appear.

// File: rtl/aal1_pkg.sv
package aal1_pkg;

    localparam int OCTET_W = 8;
    localparam int SC_W    = 3;
    localparam int SN_W    = SC_W + 1;
    localparam int CRC_W   = 3;

    typedef enum logic [1:0] {
        ST_HDR  = 2'd0,
        ST_PTR  = 2'd1,
        ST_DATA = 2'd2
    } build_state_e;

    // Serial division of sn * x^3 by x^3 + x + 1, most significant bit first.
    function automatic logic [CRC_W-1:0] sn_crc3(input logic [SN_W-1:0] sn);
        logic [CRC_W-1:0] rem;
        logic             fb;
        rem = '0;
        for (int i = SN_W - 1; i >= 0; i--) begin
            fb  = sn[i] ^ rem[CRC_W-1];
            rem = {rem[CRC_W-2:0], 1'b0} ^ (fb ? 3'b011 : 3'b000);
        end
        return rem;
    endfunction

endpackage

// File: rtl/aal1_snp_gen.sv
module aal1_snp_gen
    import aal1_pkg::*;
(
    input  logic [SN_W-1:0]    sn,
    output logic [OCTET_W-1:0] hdr_octet
);
    logic [CRC_W-1:0] crc;

    always_comb begin
        crc       = sn_crc3(sn);
        hdr_octet = {sn, crc, ^{sn, crc}};
    end
endmodule

// File: rtl/aal1_ptr_gen.sv
module aal1_ptr_gen #(
    parameter int PTR_W = 7
) (
    input  logic [PTR_W-1:0] offset,
    output logic [PTR_W:0]   ptr_octet
);
    always_comb begin
        ptr_octet = {^offset, offset};
    end
endmodule

// File: rtl/aal1_cell_builder.sv
module aal1_cell_builder
    import aal1_pkg::*;
#(
    parameter int CELL_OCTETS = 48,
    parameter int PTR_W       = OCTET_W - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [OCTET_W-1:0] in_data,
    output logic               in_ready,
    input  logic               ptr_req,
    input  logic [PTR_W-1:0]   ptr_offset,
    output logic               out_valid,
    output logic               out_sop,
    output logic [OCTET_W-1:0] out_data
);
    localparam int SDU_OCTETS = CELL_OCTETS - 1;
    localparam int CNT_W      = $clog2(CELL_OCTETS);

    typedef struct packed {
        build_state_e       state;
        logic [SC_W-1:0]    sc;
        logic [CNT_W-1:0]   left;
        logic [PTR_W:0]     ptr_oct;
        logic               out_valid;
        logic               out_sop;
        logic [OCTET_W-1:0] out_data;
    } build_regs_t;

    build_regs_t regs_d, regs_q;

    logic               use_ptr;
    logic [OCTET_W-1:0] hdr_octet;
    logic [PTR_W:0]     ptr_octet;

    assign use_ptr = ptr_req && !regs_q.sc[0];

    aal1_snp_gen u_snp (
        .sn        ({use_ptr, regs_q.sc}),
        .hdr_octet (hdr_octet)
    );

    aal1_ptr_gen #(.PTR_W(PTR_W)) u_ptr (
        .offset    (ptr_offset),
        .ptr_octet (ptr_octet)
    );

    always_comb begin
        regs_d           = regs_q;
        regs_d.out_valid = 1'b0;
        regs_d.out_sop   = 1'b0;
        unique case (regs_q.state)
            ST_HDR: begin
                if (in_valid) begin
                    regs_d.out_valid = 1'b1;
                    regs_d.out_sop   = 1'b1;
                    regs_d.out_data  = hdr_octet;
                    regs_d.sc        = regs_q.sc + 1'b1;
                    regs_d.ptr_oct   = ptr_octet;
                    regs_d.left      = use_ptr ? CNT_W'(SDU_OCTETS - 1) : CNT_W'(SDU_OCTETS);
                    regs_d.state     = use_ptr ? ST_PTR : ST_DATA;
                end
            end
            ST_PTR: begin
                regs_d.out_valid = 1'b1;
                regs_d.out_data  = regs_q.ptr_oct;
                regs_d.state     = ST_DATA;
            end
            ST_DATA: begin
                if (in_valid) begin
                    regs_d.out_valid = 1'b1;
                    regs_d.out_data  = in_data;
                    regs_d.left      = regs_q.left - 1'b1;
                    if (regs_q.left == CNT_W'(1)) begin
                        regs_d.state = ST_HDR;
                    end
                end
            end
            default: regs_d.state = ST_HDR;
        endcase
        if (rst) begin
            regs_d = '{state: ST_HDR, default: '0};
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign in_ready  = (regs_q.state == ST_DATA);
    assign out_valid = regs_q.out_valid;
    assign out_sop   = regs_q.out_sop;
    assign out_data  = regs_q.out_data;

endmodule

// File: rtl/aal1_cell_builder_chk.sv
module aal1_cell_builder_chk #(
    parameter int CELL_OCTETS = 48
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_sop,
    input logic [7:0] out_data
);
    localparam int LEN_W = $clog2(CELL_OCTETS + 1);

    logic [LEN_W-1:0] len_q;
    logic             started_q;
    logic [2:0]       last_sc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q     <= '0;
            started_q <= 1'b0;
            last_sc_q <= '0;
        end else if (out_valid) begin
            if (out_sop) begin
                len_q     <= LEN_W'(1);
                started_q <= 1'b1;
                last_sc_q <= out_data[6:4];
            end else begin
                len_q <= len_q + 1'b1;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !in_ready));

    assert_sc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (out_sop && started_q) |-> (out_data[6:4] == last_sc_q + 3'd1));

    assert_hdr_parity_R3: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> (^out_data == 1'b0));

    assert_csi_even_only_R4: assert property (@(posedge clk) disable iff (rst)
        (out_sop && out_data[7]) |-> (out_data[4] == 1'b0));

    assert_ptr_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (out_sop && out_data[7]) |=> (out_valid && !out_sop && (^out_data == 1'b0)));

    assert_stall_on_ptr_R7: assert property (@(posedge clk) disable iff (rst)
        (out_sop && out_data[7]) |-> !in_ready);

    assert_cell_len_R6: assert property (@(posedge clk) disable iff (rst)
        (out_sop && started_q) |-> (len_q == LEN_W'(CELL_OCTETS)));

    assert_sop_valid_R8: assert property (@(posedge clk) disable iff (rst)
        out_sop |-> out_valid);

    assert_data_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && !out_sop && out_data == $past(in_data)));

endmodule

bind aal1_cell_builder aal1_cell_builder_chk #(.CELL_OCTETS(CELL_OCTETS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_data  (out_data)
);

// File: tb/tb_aal1_cell_builder.sv
module tb_aal1_cell_builder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       ptr_req = 1'b0;
    logic [6:0] ptr_offset = '0;
    logic       out_valid;
    logic       out_sop;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int sops_seen = 0;
    int sops_exp = 0;
    int cell_len = 0;
    logic [7:0] cap [0:63];
    logic [2:0] exp_sc = 3'd0;

    always #2 clk = ~clk;

    aal1_cell_builder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .ptr_req(ptr_req), .ptr_offset(ptr_offset),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (out_sop) begin
                cell_len = 0;
                sops_seen++;
            end
            if (cell_len < 64) cap[cell_len] = out_data;
            cell_len++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_hdr(input logic csi, input logic [2:0] sc);
        logic [6:0] v;
        logic [3:0] sn;
        sn = {csi, sc};
        v  = {sn, 3'b000};
        for (int i = 6; i >= 3; i--) begin
            if (v[i]) v = v ^ (7'b0001011 << (i - 3));
        end
        return {sn, v[2:0], ^{sn, v[2:0]}};
    endfunction

    task automatic send_cell(input bit req, input logic [6:0] off, input logic [7:0] base,
                             input bit gaps);
        bit   use_ptr = req && !exp_sc[0];
        int   n = use_ptr ? 46 : 47;
        int   sent = 0;
        int   waits = 0;
        int   bad = 0;
        bit   first = 1'b1;
        bit   phase = 1'b0;
        bit   hs;
        logic [7:0] hdr_exp = ref_hdr(use_ptr, exp_sc);
        ptr_req    = req;
        ptr_offset = off;
        sops_exp++;
        while (sent < n) begin
            in_valid = !(gaps && phase);
            phase    = !phase;
            in_data  = base + 8'(sent);
            hs = in_valid && in_ready;
            if (sent == 0 && !in_ready) waits++;
            @(negedge clk);
            if (hs) begin
                if (first) begin
                    chk(out_valid && !out_sop && out_data == base, "R9 first octet latency",
                        int'(out_data), int'(base));
                    first = 1'b0;
                end
                sent++;
            end
        end
        in_valid = 1'b0;
        ptr_req  = 1'b0;
        @(negedge clk);
        if (!gaps)
            chk(waits == (use_ptr ? 2 : 1), "R7 stall cycles before first accept",
                waits, use_ptr ? 2 : 1);
        chk(cell_len == 48, "R6 cell length", cell_len, 48);
        chk(cap[0] == hdr_exp, use_ptr ? "R4 header with pointer" :
            (req ? "R5 odd count header" : "R2 R3 header octet"), int'(cap[0]), int'(hdr_exp));
        if (use_ptr)
            chk(cap[1] == {^off, off}, "R4 pointer octet", int'(cap[1]), int'({^off, off}));
        for (int i = 0; i < n; i++) begin
            if (cap[48 - n + i] != base + 8'(i)) bad++;
        end
        chk(bad == 0, use_ptr ? "R6 46 user octets" : "R5 R7 47 user octets", bad, 0);
        exp_sc = exp_sc + 3'd1;
    endtask

    task automatic test_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        chk(!in_ready, "R1 in_ready after reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!in_ready && !out_valid, "R7 idle with no input", int'(in_ready), 0);
    endtask

    task automatic test_plain_run;
        send_cell(1'b0, 7'd0, 8'h10, 1'b0);
        send_cell(1'b0, 7'd0, 8'h40, 1'b0);
    endtask

    task automatic test_pointer_rules;
        send_cell(1'b1, 7'd5, 8'h80, 1'b0);
        send_cell(1'b1, 7'd33, 8'h20, 1'b0);
        send_cell(1'b1, 7'd127, 8'hA0, 1'b0);
        send_cell(1'b0, 7'd0, 8'h05, 1'b0);
    endtask

    task automatic test_wrap_and_gaps;
        send_cell(1'b1, 7'd64, 8'h30, 1'b1);
        send_cell(1'b0, 7'd0, 8'hC0, 1'b1);
        chk(exp_sc == 3'd0, "R2 bench count wrapped", int'(exp_sc), 0);
        send_cell(1'b1, 7'd1, 8'h60, 1'b0);
    endtask

    task automatic test_midcell_reset;
        int k = 0;
        in_valid = 1'b1;
        while (k < 10) begin
            in_data = 8'(k);
            if (in_ready) k++;
            @(negedge clk);
        end
        sops_exp++;
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(!out_valid && !in_ready, "R1 reset mid cell", int'(out_valid), 0);
        rst = 1'b0;
        exp_sc = 3'd0;
        @(negedge clk);
        send_cell(1'b0, 7'd0, 8'hE0, 1'b0);
        chk(sops_seen == sops_exp, "R8 start markers", sops_seen, sops_exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_plain_run();
        test_pointer_rules();
        test_wrap_and_gaps();
        test_midcell_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule